// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the device side of a three-wire serial EEPROM holding 64 words of 16 bits. It watches a chip-select, a serial clock and a data-in line, all synchronous to a fast system clock. It acts on every rising edge of the serial clock while chip-select is high. Each frame opens with a start bit. A two-bit opcode and a six-bit word address follow. For reads the engine shifts a stored word out on a tri-stated data-out line, and for writes it collects the data bits that follow the address.

Programming never starts inside a frame. It starts when chip-select falls after a complete address has arrived. A counter stands in for the self-timed programming cycle. While that counter runs, the engine reports busy on data-out and ignores new instructions. When the cycle ends it reports ready, and it keeps reporting ready until the host clocks in a new start bit. The storage array is built from ordinary flops and resets to the erased state.

Top module: `eep_engine`

## Requirements
- R1: While chip-select is high and no frame is open, 0 bits on data-in are ignored. The first 1 sampled on a serial clock rising edge is taken as the start bit. Data-in is only sampled on rising edges of the serial clock.
- R2: After the start bit come a 2-bit opcode and a 6-bit address, each sent MSB first. The opcodes are: 10 read, 01 write, 11 erase. Opcode 00 takes the top two address bits as a sub-code: 11 enable, 00 disable, 10 erase-all, 01 write-all. The other four address bits are don't-care.
- R3: A read turns data-out on with a 0 dummy bit on the same serial clock rising edge that samples the last address bit. Each later rising edge then presents the next bit of the addressed word, MSB first.
- R4: Chip-select low aborts any open frame. A chip-select rise also resets the decoder, so the next 1 on data-in starts a fresh frame.
- R5: A programming instruction (write, erase, erase-all, write-all) is carried out only when chip-select falls after the start bit, opcode and all six address bits have been received. A frame cut short before that programs nothing.
- R6: A write stores the last 16 bits sampled after the address. If fewer than 16 arrived, the missing high bits are 0.
- R7: Erase sets the addressed word to 0xFFFF. Erase-all sets every word to 0xFFFF. Write-all stores the data word into all 64 locations.
- R8: Programming is refused unless an enable instruction has completed since reset and no disable has completed after it. A refused instruction changes no word and raises no busy status.
- R9: After an accepted programming instruction, data-out is driven while chip-select is high: 0 while busy and 1 once done. This status persists across frames until a start bit is clocked in, which returns data-out to high impedance.
- R10: The busy period lasts BUSY_CYC system clock cycles. While it runs, a 1 on data-in is not taken as a start bit.
- R11: After reset, data-out is undriven and every word reads 0xFFFF. Data-out is only driven while chip-select is high, and only for read data or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip-select from host, active high |
| sk | input | 1 | Serial clock from host; rising edges act |
| di | input | 1 | Serial data from host |
| do_oe | output | 1 | Output enable of the tri-stated data-out pad |
| do_data | output | 1 | Value driven on data-out when do_oe is high |

## Verification
The bench clocks zeros ahead of the start bit. A decoder that reacted to the first edge instead of the first 1 would misalign the whole frame and return the wrong word. It drops chip-select one bit short of a full address, and again after only four data bits. Launching too early would corrupt a word, and launching too late would lose the short write. It pulses a 1 during the busy window and checks that status stays low. An engine that took that bit as a start would clear the status early. Random writes and reads against a bench model of the array, together with erase-all, write-all and disable, would expose a wrong opcode sub-decode or a write that ignored the enable state.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    C_READ, C_WRITE, C_ERASE, C_EWEN, C_EWDS, C_ERAL, C_WRAL
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_RDATA, S_WDATA, S_HOLD
  } st_e;

  // Opcode plus top address bits to an instruction
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] sub);
    cmd_e c;
    case (op)
      2'b10:   c = C_READ;
      2'b01:   c = C_WRITE;
      2'b11:   c = C_ERASE;
      default: begin
        case (sub)
          2'b11:   c = C_EWEN;
          2'b10:   c = C_ERAL;
          2'b01:   c = C_WRAL;
          default: c = C_EWDS;
        endcase
      end
    endcase
    return c;
  endfunction

  function automatic logic is_prog(input cmd_e c);
    return (c == C_WRITE) || (c == C_ERASE) || (c == C_ERAL) || (c == C_WRAL);
  endfunction

  function automatic logic is_bulk(input cmd_e c);
    return (c == C_ERAL) || (c == C_WRAL);
  endfunction

  function automatic logic takes_data(input cmd_e c);
    return (c == C_WRITE) || (c == C_WRAL);
  endfunction

endpackage

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_one,
  input  logic          we_all,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = we_all || (we_one && (waddr == AW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '1;
      else if (hit) q <= wdata;
    end
    assign words[i] = q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int BUSY_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(BUSY_CYC + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (start)       remain <= TW'(BUSY_CYC);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/eep_decoder.sv
module eep_decoder
  import eep_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_q,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sk_rise,
  input  logic          di_q,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          start_evt,
  output logic          rd_phase,
  output logic          rd_bit,
  output logic          launch,
  output cmd_e          launch_cmd,
  output logic [AW-1:0] launch_addr,
  output logic [DW-1:0] launch_data,
  output logic          enabled
);
  localparam int FB = 2 + AW;            // opcode plus address bits
  localparam int CW = $clog2(FB + 1);

  st_e           st;
  logic [CW-1:0] bitcnt;
  logic [FB-1:0] cmd_sr;
  logic [FB-1:0] full_cmd;
  cmd_e          cur_cmd;
  cmd_e          nxt_cmd;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] dat_sr;
  logic [DW:0]   rd_sr;
  logic          en_q;
  logic          last_hdr;

  assign full_cmd  = {cmd_sr[FB-2:0], di_q};
  assign nxt_cmd   = decode_cmd(full_cmd[FB-1 -: 2], full_cmd[AW-1 -: 2]);
  assign rd_addr   = full_cmd[AW-1:0];
  assign last_hdr  = (st == S_CMD) && sk_rise && (bitcnt == CW'(FB - 1));
  assign start_evt = cs_q && !cs_rise && sk_rise && (st == S_IDLE) && di_q && !busy;
  assign launch    = cs_fall && en_q &&
                     ((st == S_WDATA) || ((st == S_HOLD) && is_prog(cur_cmd)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      cmd_sr   <= '0;
      cur_cmd  <= C_EWDS;
      cur_addr <= '0;
      dat_sr   <= '0;
      rd_sr    <= '0;
      en_q     <= 1'b0;
    end else if (!cs_q || cs_rise) begin
      st <= S_IDLE;
    end else if (sk_rise) begin
      case (st)
        S_IDLE: if (start_evt) begin
          st     <= S_CMD;
          bitcnt <= '0;
          dat_sr <= '0;
        end
        S_CMD: begin
          cmd_sr <= full_cmd;
          bitcnt <= bitcnt + 1'b1;
          if (last_hdr) begin
            cur_cmd  <= nxt_cmd;
            cur_addr <= full_cmd[AW-1:0];
            if (nxt_cmd == C_READ) begin
              st    <= S_RDATA;
              rd_sr <= {1'b0, rd_word};
            end else if (takes_data(nxt_cmd)) begin
              st <= S_WDATA;
            end else begin
              st <= S_HOLD;
              if (nxt_cmd == C_EWEN) en_q <= 1'b1;
              if (nxt_cmd == C_EWDS) en_q <= 1'b0;
            end
          end
        end
        S_RDATA: rd_sr  <= {rd_sr[DW-1:0], 1'b0};
        S_WDATA: dat_sr <= {dat_sr[DW-2:0], di_q};
        default: ;
      endcase
    end
  end

  assign rd_phase    = (st == S_RDATA);
  assign rd_bit      = rd_sr[DW];
  assign launch_cmd  = cur_cmd;
  assign launch_addr = cur_addr;
  assign launch_data = dat_sr;
  assign enabled     = en_q;
endmodule

// File: rtl/eep_engine.sv
module eep_engine
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_oe,
  output logic do_data
);
  logic cs_q, cs_p, sk_q, sk_p, di_q;
  logic cs_rise, cs_fall, sk_rise;
  logic busy, stat_pend, start_evt, rd_phase, rd_bit, launch, enabled;
  cmd_e              launch_cmd;
  logic [ADDR_W-1:0] rd_addr, launch_addr;
  logic [DATA_W-1:0] rd_word, launch_data, wdata;
  logic              we_one, we_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0; cs_p <= 1'b0; sk_q <= 1'b0; sk_p <= 1'b0; di_q <= 1'b0;
    end else begin
      cs_q <= cs; cs_p <= cs_q; sk_q <= sk; sk_p <= sk_q; di_q <= di;
    end
  end

  assign cs_rise = cs_q && !cs_p;
  assign cs_fall = !cs_q && cs_p;
  assign sk_rise = sk_q && !sk_p;

  eep_decoder #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di_q(di_q), .busy(busy), .rd_word(rd_word),
    .rd_addr(rd_addr), .start_evt(start_evt), .rd_phase(rd_phase), .rd_bit(rd_bit),
    .launch(launch), .launch_cmd(launch_cmd), .launch_addr(launch_addr),
    .launch_data(launch_data), .enabled(enabled)
  );

  assign we_one = launch && !is_bulk(launch_cmd);
  assign we_all = launch &&  is_bulk(launch_cmd);
  assign wdata  = takes_data(launch_cmd) ? launch_data : '1;

  eep_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
    .waddr(launch_addr), .wdata(wdata), .raddr(rd_addr), .rdata(rd_word)
  );

  eep_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_pend <= 1'b0;
    else if (launch)    stat_pend <= 1'b1;
    else if (start_evt) stat_pend <= 1'b0;
  end

  assign do_oe   = cs_q && (rd_phase || stat_pend);
  assign do_data = rd_phase ? rd_bit : !busy;
endmodule

// File: rtl/eep_engine_chk.sv
module eep_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_oe,
  input logic do_data,
  input logic busy,
  input logic rd_phase,
  input logic launch,
  input logic cs_fall,
  input logic start_evt,
  input logic stat_pend
);
  AST_OE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe); // R11
  AST_LAUNCH_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> cs_fall); // R5
  AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R10
  AST_READ_DUMMY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_phase) |-> (do_oe && !do_data)); // R3
  AST_STATUS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && busy && do_oe) |-> !do_data); // R9
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !stat_pend); // R9
endmodule

bind eep_engine eep_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_oe(do_oe), .do_data(do_data),
  .busy(busy), .rd_phase(rd_phase), .launch(launch), .cs_fall(cs_fall),
  .start_evt(start_evt), .stat_pend(stat_pend)
);

// File: tb/sim_eep_engine.sv
module sim_eep_engine;
  localparam int CLK_P = 10;
  localparam int BUSY  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_oe, do_data;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [15:0] mdl [64];
  bit   mdl_en = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  eep_engine #(.ADDR_W(6), .DATA_W(16), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_oe(do_oe), .do_data(do_data)
  );

  function automatic logic [8:0] frame(input logic [1:0] op, input logic [5:0] a);
    return {1'b1, op, a};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b; sk = 1'b0; tick(2);
    sk = 1'b1; tick(3);
  endtask

  task automatic cs_up();
    sk = 1'b0; di = 1'b0; cs = 1'b1; tick(3);
  endtask

  task automatic cs_dn();
    sk = 1'b0; di = 1'b0; cs = 1'b0; tick(3);
  endtask

  task automatic send(input logic [8:0] f, input int nbits);
    for (int i = 8; i > 8 - nbits; i--) sk_bit(f[i]);
  endtask

  task automatic read_word(input logic [5:0] a, output logic [15:0] w, output logic dummy_ok);
    cs_up();
    send(frame(2'b10, a), 9);
    dummy_ok = (do_oe === 1'b1) && (do_data === 1'b0);
    for (int i = 15; i >= 0; i--) begin
      sk_bit(1'b0);
      w[i] = do_data;
    end
    cs_dn();
  endtask

  task automatic prog(input logic [1:0] op, input logic [5:0] a,
                      input logic [31:0] d, input int nd);
    cs_up();
    send(frame(op, a), 9);
    for (int i = nd - 1; i >= 0; i--) sk_bit(d[i]);
    cs_dn();
    tick(BUSY + 5);
  endtask

  task automatic expect_word(input string req, input logic [5:0] a, input logic [15:0] e);
    logic [15:0] w; logic dk;
    read_word(a, w, dk);
    check(req, {15'd0, dk}, 32'd1);
    check(req, {16'd0, w}, {16'd0, e});
  endtask

  initial begin
    logic [15:0] w; logic dk;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
    tick(3); rst_n = 1'b1; tick(2);

    // R11 reset: undriven, erased contents
    check("R11", {31'd0, do_oe}, 32'd0);
    cs_up(); check("R11", {31'd0, do_oe}, 32'd0); cs_dn();
    read_word(6'd9, w, dk);
    check("R3", {31'd0, dk}, 32'd1);
    check("R11", {16'd0, w}, 32'h0000FFFF);

    // R8: write refused before enable, no status
    prog(2'b01, 6'd5, 32'h1234, 16);
    cs_up(); check("R8", {31'd0, do_oe}, 32'd0); cs_dn();
    expect_word("R8", 6'd5, 16'hFFFF);

    // enable (extra don't-care address bits and trailing clocks)
    cs_up(); send(frame(2'b00, 6'b11_1010), 9); sk_bit(1'b1); sk_bit(1'b0); cs_dn();
    mdl_en = 1'b1;

    // R1 leading zeros; R9/R10 status timing
    cs_up(); sk_bit(0); sk_bit(0); sk_bit(0);
    send(frame(2'b01, 6'd5), 9);
    for (int i = 15; i >= 0; i--) sk_bit(16'hBEEF >> i);
    cs_dn(); cs_up();
    check("R9", {30'd0, do_oe, do_data}, 32'b10);
    sk_bit(1'b1);                             // R10 ignored while busy
    check("R10", {30'd0, do_oe, do_data}, 32'b10);
    tick(BUSY - 20);
    check("R10", {31'd0, do_data}, 32'd0);
    tick(20);
    check("R9", {30'd0, do_oe, do_data}, 32'b11);
    cs_dn(); check("R11", {31'd0, do_oe}, 32'd0);
    cs_up(); check("R9", {30'd0, do_oe, do_data}, 32'b11);
    sk_bit(1'b0); check("R9", {31'd0, do_oe}, 32'd1);
    sk_bit(1'b1); check("R9", {31'd0, do_oe}, 32'd0);
    cs_dn();
    mdl[5] = 16'hBEEF;
    expect_word("R1", 6'd5, 16'hBEEF);

    // R5: cut short one address bit early
    cs_up(); send(frame(2'b11, 6'd5), 8); cs_dn(); tick(BUSY + 5);
    expect_word("R5", 6'd5, 16'hBEEF);
    // R4: abort a read mid header, then a fresh read decodes cleanly
    cs_up(); send(frame(2'b10, 6'd5), 4); cs_dn();
    expect_word("R4", 6'd5, 16'hBEEF);
    // R4: chip-select rise resets without a low phase long enough to read
    cs_up(); send(frame(2'b01, 6'd3), 5); cs = 1'b0; tick(1); cs = 1'b1; tick(3);
    send(frame(2'b10, 6'd5), 9); check("R4", {30'd0, do_oe, do_data}, 32'b10); cs_dn();

    // R6: short data field and over-long data field
    prog(2'b01, 6'd12, 32'hB, 4);   mdl[12] = 16'h000B;
    expect_word("R6", 6'd12, 16'h000B);
    prog(2'b01, 6'd13, 32'hF_1357, 20); mdl[13] = 16'h1357;
    expect_word("R6", 6'd13, 16'h1357);

    // R7 erase, write-all, erase-all
    prog(2'b11, 6'd13, 0, 0); mdl[13] = 16'hFFFF;
    expect_word("R7", 6'd13, 16'hFFFF);
    expect_word("R7", 6'd12, 16'h000B);
    prog(2'b00, 6'b01_0110, 32'hA5C3, 16);
    for (int i = 0; i < 64; i++) mdl[i] = 16'hA5C3;
    expect_word("R7", 6'd0, 16'hA5C3);
    expect_word("R7", 6'd63, 16'hA5C3);
    prog(2'b00, 6'b10_0001, 0, 0);
    for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
    expect_word("R7", 6'd31, 16'hFFFF);

    // R2 random writes/reads against model
    for (int k = 0; k < 30; k++) begin
      logic [5:0] a; logic [15:0] d;
      a = 6'($urandom_range(0, 63));
      d = 16'($urandom);
      if ($urandom_range(0, 2) != 0) begin
        prog(2'b01, a, {16'd0, d}, 16);
        if (mdl_en) mdl[a] = d;
      end
      a = 6'($urandom_range(0, 63));
      expect_word("R2", a, mdl[a]);
    end

    // R8 disable blocks later writes
    cs_up(); send(frame(2'b00, 6'b00_0101), 9); cs_dn(); mdl_en = 1'b0;
    prog(2'b01, 6'd20, 32'h0F0F, 16);
    expect_word("R8", 6'd20, mdl[20]);
    prog(2'b00, 6'b10_0000, 0, 0);
    expect_word("R8", 6'd21, mdl[21]);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule